// File: doc/BRIEF.md
# Write-No-Allocate Cache Level

This block is one level of a data cache hierarchy. It sits between a requester above and a slower memory port below. Both ports carry a byte address, a read/write flag and one 64-bit double-word, and both use the same exchange. A request is taken when `req` and `ready` are both high. The answer comes back later as a one-cycle `done` pulse, and read data travels with that pulse.

Parameters set the line size, the line count, the number of ways, a fixed lookup time, the write policy (write-back or write-through) and the victim policy (least-recently-used, or a free-running shift-register generator). Every access spends the lookup time before its outcome is known. A read that misses fetches the whole line from below, one double-word per transfer. If the victim line is dirty, the line is written out first. A write that misses is passed downward unchanged, and no line is created for it. With default parameters the level is direct-mapped, with eight 16-byte lines, a 2-cycle lookup and write-back.

Top module: `nwa_cache`

## Requirements
- R1: While reset is low and on the first cycle after it is released, `up_ready` is 1, `up_done` is 0 and `dn_req` is 0.
- R2: An address splits into a byte offset in its low log2(BLOCK_BYTES) bits, a set index in the next log2(NUM_BLOCKS/WAYS) bits, and a tag in the bits above. A read hit pulses `up_done` exactly HIT_LAT cycles after the accepting edge, returns the stored double-word and causes no lower-port request.
- R3: A read miss fetches every double-word of the line with lower reads at line base + 8·k, with k ascending from 0. It then returns the requested double-word, with `up_done` later than HIT_LAT cycles. Lower addresses are always multiples of 8.
- R4: In write-back mode a write hit updates only this level: there is no lower request, `up_done` comes after HIT_LAT cycles, and later reads return the new data.
- R5: In write-through mode a write hit updates this level and also issues exactly one lower write with the same address and data before `up_done`.
- R6: A write miss issues exactly one lower write with the same address and data and allocates no line, so a following read of that address misses.
- R7: In write-back mode, a read miss whose victim is valid and dirty first writes the whole victim line below, lowest double-word first. Only then does it issue the refill reads.
- R8: A victim that is clean, or any victim in write-through mode, causes no lower write.
- R9: The victim is the lowest-numbered invalid way if one exists. Otherwise, with LRU selected, it is the least recently used way, where read hits, write hits and refills count as use and write misses do not.
- R10: `up_ready` drops on the cycle after an acceptance and stays low until the cycle where `up_done` pulses for one cycle. While `dn_ready` is low, `dn_req` holds its address and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req | input | 1 | Upper request valid |
| up_we | input | 1 | Upper request is a write |
| up_addr | input | ADDR_W | Upper byte address |
| up_wdata | input | 64 | Upper write data |
| up_ready | output | 1 | Level can accept a request |
| up_done | output | 1 | One-cycle completion pulse |
| up_rdata | output | 64 | Read data, valid with `up_done` |
| dn_req | output | 1 | Lower request valid |
| dn_we | output | 1 | Lower request is a write |
| dn_addr | output | ADDR_W | Lower byte address |
| dn_wdata | output | 64 | Lower write data |
| dn_ready | input | 1 | Lower port can accept |
| dn_done | input | 1 | Lower completion pulse |
| dn_rdata | input | 64 | Lower read data, valid with `dn_done` |

## Verification
The properties assume the following about the neighbours:
- The upper side raises `up_req` only while `up_ready` is high.
- The lower side pulses `dn_done` once for each request it has accepted, and never before accepting one.
- The lower side holds no more than one request at a time.

The bench's memory model meets these by design: it lowers `dn_ready` while busy and completes after a fixed delay. The driver waits for both cache instances to answer before it issues the next access.

// File: rtl/nwa_cache_pkg.sv
package nwa_cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FWD,
    ST_WBK,
    ST_FILL
  } nwa_state_e;

  function automatic int width_min1(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/nwa_lfsr.sv
module nwa_lfsr #(
  parameter int          OUT_W = 1,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd_o
);
  logic [15:0] q, q_n;

  always_comb q_n = {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= SEED;
    else        q <= q_n;

  assign rnd_o = q[OUT_W-1:0];
endmodule

// File: rtl/nwa_victim_sel.sv
module nwa_victim_sel #(
  parameter int WAYS    = 2,
  parameter int WAY_W   = 1,
  parameter bit USE_LRU = 1'b1
) (
  input  logic [WAYS-1:0]       valid_i,
  input  logic [WAYS*WAY_W-1:0] age_i,
  input  logic [WAY_W-1:0]      rnd_i,
  output logic [WAY_W-1:0]      way_o
);
  always_comb begin
    way_o = rnd_i;
    for (int w = 0; w < WAYS; w++)
      if (USE_LRU && age_i[w*WAY_W +: WAY_W] == WAY_W'(WAYS-1)) way_o = WAY_W'(w);
    for (int w = WAYS-1; w >= 0; w--)
      if (!valid_i[w]) way_o = WAY_W'(w);
    if (WAYS == 1) way_o = '0;
  end
endmodule

// File: rtl/nwa_cache.sv
module nwa_cache import nwa_cache_pkg::*; #(
  parameter int          ADDR_W        = 32,
  parameter int          BLOCK_BYTES   = 16,
  parameter int          NUM_BLOCKS    = 8,
  parameter int          WAYS          = 1,
  parameter int          HIT_LAT       = 2,
  parameter bit          WRITE_THROUGH = 1'b0,
  parameter bit          USE_LRU       = 1'b1,
  parameter logic [15:0] LFSR_SEED     = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req,
  input  logic              up_we,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [63:0]       up_wdata,
  output logic              up_ready,
  output logic              up_done,
  output logic [63:0]       up_rdata,
  output logic              dn_req,
  output logic              dn_we,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [63:0]       dn_wdata,
  input  logic              dn_ready,
  input  logic              dn_done,
  input  logic [63:0]       dn_rdata
);
  localparam int WORDS    = BLOCK_BYTES / 8;
  localparam int NUM_SETS = NUM_BLOCKS / WAYS;
  localparam int OFF_W    = $clog2(BLOCK_BYTES);
  localparam int SET_BITS = $clog2(NUM_SETS);
  localparam int SET_W    = width_min1(NUM_SETS);
  localparam int WIDX_W   = width_min1(WORDS);
  localparam int WAY_W    = width_min1(WAYS);
  localparam int TAG_W    = ADDR_W - OFF_W - SET_BITS;
  localparam int CNT_W    = width_min1(HIT_LAT);

  // storage
  logic [WAYS-1:0]  valid_q [NUM_SETS];
  logic [WAYS-1:0]  dirty_q [NUM_SETS];
  logic [TAG_W-1:0] tag_q   [NUM_SETS][WAYS];
  logic [WAY_W-1:0] age_q   [NUM_SETS][WAYS];
  logic [63:0]      data_q  [NUM_SETS][WAYS][WORDS];

  // control state
  nwa_state_e        st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [WIDX_W-1:0] beat_q, beat_n;
  logic [WAY_W-1:0]  way_q, way_n;
  logic              issued_q, issued_n, done_q, done_n;
  logic [63:0]       rdata_q, rdata_n;
  logic              r_we_q;
  logic [ADDR_W-1:0] r_addr_q;
  logic [63:0]       r_wdata_q;

  // decoded request and strobes
  logic [SET_W-1:0]      r_set;
  logic [TAG_W-1:0]      r_tag;
  logic [WIDX_W-1:0]     r_wsel;
  logic                  hit, take, wr_hit, touch, fill_word, fill_done, got, last_beat;
  logic [WAY_W-1:0]      hit_way, touch_way, vic_way, rnd;
  logic [WAYS*WAY_W-1:0] ages_flat;
  logic [ADDR_W-1:0]     beat_off, wb_base, fill_base;

  assign r_set     = SET_W'((r_addr_q >> OFF_W) % NUM_SETS);
  assign r_tag     = TAG_W'(r_addr_q >> (OFF_W + SET_BITS));
  assign r_wsel    = WIDX_W'((r_addr_q >> 3) % WORDS);
  assign got       = dn_done && issued_q;
  assign last_beat = (beat_q == WIDX_W'(WORDS-1));

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      ages_flat[w*WAY_W +: WAY_W] = age_q[r_set][w];
      if (valid_q[r_set][w] && tag_q[r_set][w] == r_tag) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  generate
    if (!USE_LRU && WAYS > 1) begin : g_rnd
      nwa_lfsr #(.OUT_W(WAY_W), .SEED(LFSR_SEED)) u_lfsr (.clk(clk), .rst_n(rst_n), .rnd_o(rnd));
    end else begin : g_norand
      assign rnd = '0;
    end
  endgenerate

  nwa_victim_sel #(.WAYS(WAYS), .WAY_W(WAY_W), .USE_LRU(USE_LRU)) u_vic (
    .valid_i(valid_q[r_set]), .age_i(ages_flat), .rnd_i(rnd), .way_o(vic_way));

  // next-state logic
  always_comb begin
    st_n = st_q; cnt_n = cnt_q; beat_n = beat_q; way_n = way_q;
    done_n = 1'b0; rdata_n = rdata_q;
    take = 1'b0; wr_hit = 1'b0; touch = 1'b0; touch_way = hit_way;
    fill_word = 1'b0; fill_done = 1'b0;
    issued_n = issued_q;
    if (dn_req && dn_ready) issued_n = 1'b1;
    if (got)                issued_n = 1'b0;
    unique case (st_q)
      ST_IDLE: if (up_req) begin
        take  = 1'b1;
        st_n  = ST_LOOK;
        cnt_n = CNT_W'(HIT_LAT - 1);
      end
      ST_LOOK: begin
        if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
        else if (hit) begin
          touch = 1'b1;
          if (!r_we_q) begin
            rdata_n = data_q[r_set][hit_way][r_wsel];
            done_n  = 1'b1;
            st_n    = ST_IDLE;
          end else begin
            wr_hit = 1'b1;
            if (WRITE_THROUGH) st_n = ST_FWD;
            else begin done_n = 1'b1; st_n = ST_IDLE; end
          end
        end else if (r_we_q) st_n = ST_FWD;
        else begin
          way_n  = vic_way;
          beat_n = '0;
          st_n   = (!WRITE_THROUGH && valid_q[r_set][vic_way] && dirty_q[r_set][vic_way])
                   ? ST_WBK : ST_FILL;
        end
      end
      ST_FWD: if (got) begin done_n = 1'b1; st_n = ST_IDLE; end
      ST_WBK: if (got) begin
        if (last_beat) begin beat_n = '0; st_n = ST_FILL; end
        else beat_n = beat_q + 1'b1;
      end
      ST_FILL: if (got) begin
        fill_word = 1'b1;
        if (beat_q == r_wsel) rdata_n = dn_rdata;
        if (last_beat) begin
          fill_done = 1'b1;
          touch     = 1'b1;
          touch_way = way_q;
          done_n    = 1'b1;
          st_n      = ST_IDLE;
        end else beat_n = beat_q + 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; beat_q <= '0; way_q <= '0;
      issued_q <= 1'b0; done_q <= 1'b0; rdata_q <= '0;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; beat_q <= beat_n; way_q <= way_n;
      issued_q <= issued_n; done_q <= done_n; rdata_q <= rdata_n;
    end

  always_ff @(posedge clk)
    if (take) begin
      r_we_q    <= up_we;
      r_addr_q  <= up_addr;
      r_wdata_q <= up_wdata;
    end

  // line state
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else begin
      if (fill_done) begin
        valid_q[r_set][way_q] <= 1'b1;
        dirty_q[r_set][way_q] <= 1'b0;
      end
      if (wr_hit && !WRITE_THROUGH) dirty_q[r_set][hit_way] <= 1'b1;
      if (touch)
        for (int v = 0; v < WAYS; v++)
          if (WAY_W'(v) == touch_way) age_q[r_set][v] <= '0;
          else if (age_q[r_set][v] < age_q[r_set][touch_way])
            age_q[r_set][v] <= age_q[r_set][v] + 1'b1;
    end

  always_ff @(posedge clk) begin
    if (wr_hit)    data_q[r_set][hit_way][r_wsel] <= r_wdata_q;
    if (fill_word) data_q[r_set][way_q][beat_q]   <= dn_rdata;
    if (fill_done) tag_q[r_set][way_q]            <= r_tag;
  end

  // lower port
  assign beat_off  = ADDR_W'(beat_q) << 3;
  assign wb_base   = (ADDR_W'(tag_q[r_set][way_q]) << (OFF_W + SET_BITS)) | (ADDR_W'(r_set) << OFF_W);
  assign fill_base = r_addr_q & ~ADDR_W'(BLOCK_BYTES - 1);

  always_comb begin
    dn_req   = (st_q == ST_FWD || st_q == ST_WBK || st_q == ST_FILL) && !issued_q;
    dn_we    = (st_q != ST_FILL);
    dn_addr  = r_addr_q;
    dn_wdata = r_wdata_q;
    if (st_q == ST_WBK) begin
      dn_addr  = wb_base | beat_off;
      dn_wdata = data_q[r_set][way_q][beat_q];
    end else if (st_q == ST_FILL) dn_addr = fill_base | beat_off;
  end

  assign up_ready = (st_q == ST_IDLE);
  assign up_done  = done_q;
  assign up_rdata = rdata_q;
endmodule

// File: rtl/nwa_cache_chk.sv
module nwa_cache_chk #(
  parameter int HIT_LAT = 2,
  parameter int ADDR_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_req,
  input logic              up_ready,
  input logic              up_done,
  input logic              dn_req,
  input logic              dn_ready,
  input logic              dn_we,
  input logic [ADDR_W-1:0] dn_addr
);
  localparam int LW = $clog2(HIT_LAT + 1) + 1;
  logic          busy;
  logic [LW-1:0] lat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      lat  <= '0;
    end else if (up_req && up_ready) begin
      busy <= 1'b1;
      lat  <= '0;
    end else begin
      if (up_done) busy <= 1'b0;
      if (busy && lat < LW'(HIT_LAT)) lat <= lat + 1'b1;
    end

  assert_ready_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req && up_ready) |=> !up_ready);
  assert_ready_until_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !up_ready |=> (!up_ready || up_done));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    up_done |=> !up_done);
  assert_min_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    up_done |-> (busy && lat >= LW'(HIT_LAT)));
  assert_dn_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && !dn_ready) |=> (dn_req && $stable(dn_addr) && $stable(dn_we)));
  assert_dn_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> (dn_addr[2:0] == 3'b000));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready |-> !dn_req);
endmodule

bind nwa_cache nwa_cache_chk #(.HIT_LAT(HIT_LAT), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_ready(up_ready), .up_done(up_done),
  .dn_req(dn_req), .dn_ready(dn_ready), .dn_we(dn_we), .dn_addr(dn_addr));

// File: tb/nwa_cache_test.sv
module nwa_mem_model #(parameter int LAT = 4) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [31:0] addr,
  input  logic [63:0] wdata,
  output logic        ready,
  output logic        done,
  output logic [63:0] rdata
);
  logic [63:0] mem [logic [31:0]];
  logic        busy, l_we;
  logic [31:0] l_addr;
  logic [63:0] l_data;
  int          cnt;
  logic [31:0] log_addr [64];
  logic        log_we   [64];
  logic [63:0] log_data [64];
  int          n_log;

  assign ready = !busy;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; n_log <= 0; cnt <= 0; rdata <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (cnt == 0) begin
          done <= 1'b1;
          busy <= 1'b0;
          if (l_we) mem[l_addr] = l_data;
          else rdata <= mem.exists(l_addr) ? mem[l_addr] : {l_addr, l_addr ^ 32'h5A5A_5A5A};
        end else cnt <= cnt - 1;
      end else if (req) begin
        busy <= 1'b1; cnt <= LAT;
        l_we <= we; l_addr <= addr; l_data <= wdata;
        if (n_log < 64) begin
          log_addr[n_log] <= addr; log_we[n_log] <= we; log_data[n_log] <= wdata;
        end
        n_log <= n_log + 1;
      end
    end
endmodule

module nwa_cache_test;
  localparam int HIT = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, up_req, up_we;
  logic [31:0] up_addr;
  logic [63:0] up_wdata;
  logic        rdy_a, done_a, rdy_b, done_b;
  logic [63:0] rd_a, rd_b;
  logic        dq_a, dw_a, dr_a, dd_a, dq_b, dw_b, dr_b, dd_b;
  logic [31:0] da_a, da_b;
  logic [63:0] dwd_a, dwd_b, drd_a, drd_b;

  nwa_cache #(.BLOCK_BYTES(16), .NUM_BLOCKS(8), .WAYS(2), .HIT_LAT(HIT),
              .WRITE_THROUGH(1'b0), .USE_LRU(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_we(up_we), .up_addr(up_addr),
    .up_wdata(up_wdata), .up_ready(rdy_a), .up_done(done_a), .up_rdata(rd_a),
    .dn_req(dq_a), .dn_we(dw_a), .dn_addr(da_a), .dn_wdata(dwd_a),
    .dn_ready(dr_a), .dn_done(dd_a), .dn_rdata(drd_a));
  nwa_mem_model mdl_a (.clk(clk), .rst_n(rst_n), .req(dq_a), .we(dw_a), .addr(da_a),
    .wdata(dwd_a), .ready(dr_a), .done(dd_a), .rdata(drd_a));

  nwa_cache #(.BLOCK_BYTES(16), .NUM_BLOCKS(8), .WAYS(2), .HIT_LAT(HIT),
              .WRITE_THROUGH(1'b1), .USE_LRU(1'b1)) uut_wt (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_we(up_we), .up_addr(up_addr),
    .up_wdata(up_wdata), .up_ready(rdy_b), .up_done(done_b), .up_rdata(rd_b),
    .dn_req(dq_b), .dn_we(dw_b), .dn_addr(da_b), .dn_wdata(dwd_b),
    .dn_ready(dr_b), .dn_done(dd_b), .dn_rdata(drd_b));
  nwa_mem_model mdl_b (.clk(clk), .rst_n(rst_n), .req(dq_b), .we(dw_b), .addr(da_b),
    .wdata(dwd_b), .ready(dr_b), .done(dd_b), .rdata(drd_b));

  typedef struct {bit we; logic [31:0] a; logic [63:0] d; bit fast; string tag;} item_t;
  item_t q_a[$], q_b[$];
  logic [63:0] ref_mem [logic [31:0]];
  int cyc = 0, t_acc = 0, n_iss = 0, n_a = 0, n_b = 0, n_chk = 0, n_err = 0;
  bit  over = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] ref_rd(logic [31:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : {a, a ^ 32'h5A5A_5A5A};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mon(item_t it, logic [63:0] rd, string who);
    int lat = cyc - t_acc;
    if (!it.we) chk(rd == it.d, {it.tag, " data ", who}, rd, it.d);
    if (it.fast) chk(lat == HIT, {it.tag, " hit latency ", who}, 64'(lat), 64'(HIT));
    else         chk(lat > HIT, {it.tag, " miss latency ", who}, 64'(lat), 64'(HIT + 1));
  endtask

  always @(negedge clk) begin
    if (done_a) begin
      if (q_a.size() == 0) chk(0, "R10 unexpected done wb", 1, 0);
      else mon(q_a.pop_front(), rd_a, "wb");
      n_a++;
    end
    if (done_b) begin
      if (q_b.size() == 0) chk(0, "R10 unexpected done wt", 1, 0);
      else mon(q_b.pop_front(), rd_b, "wt");
      n_b++;
    end
  end

  task automatic op(bit we, logic [31:0] a, logic [63:0] d, bit fa, bit fb, string tag);
    item_t it;
    it.we = we; it.a = a; it.d = we ? d : ref_rd(a); it.tag = tag;
    if (we) ref_mem[a] = d;
    it.fast = fa; q_a.push_back(it);
    it.fast = fb; q_b.push_back(it);
    @(negedge clk);
    up_req = 1'b1; up_we = we; up_addr = a; up_wdata = d;
    @(posedge clk); #1;
    t_acc = cyc; up_req = 1'b0; n_iss++;
    chk(!rdy_a && !rdy_b, "R10 ready low after accept", {62'd0, rdy_a, rdy_b}, 0);
    wait (n_a == n_iss && n_b == n_iss);
    @(negedge clk);
  endtask

  task automatic chk_log(bit wt, int idx, bit we, logic [31:0] a, logic [63:0] d, string tag);
    logic aw; logic [31:0] aa; logic [63:0] ad;
    aw = wt ? mdl_b.log_we[idx]   : mdl_a.log_we[idx];
    aa = wt ? mdl_b.log_addr[idx] : mdl_a.log_addr[idx];
    ad = wt ? mdl_b.log_data[idx] : mdl_a.log_data[idx];
    chk(aw == we && aa == a, {tag, " lower op/addr"}, {31'd0, aw, aa}, {31'd0, we, a});
    if (we) chk(ad == d, {tag, " lower wdata"}, ad, d);
  endtask

  task automatic chk_cnt(int ba, int bb, int ea, int eb, string tag);
    chk(mdl_a.n_log - ba == ea, {tag, " lower count wb"}, 64'(mdl_a.n_log - ba), 64'(ea));
    chk(mdl_b.n_log - bb == eb, {tag, " lower count wt"}, 64'(mdl_b.n_log - bb), 64'(eb));
  endtask

  localparam logic [63:0] W1 = 64'h1111_2222_3333_4444;
  localparam logic [63:0] W2 = 64'hDEAD_BEEF_0BAD_F00D;

  initial begin
    int ba, bb;
    rst_n = 1'b0; up_req = 1'b0; up_we = 1'b0; up_addr = '0; up_wdata = '0;
    repeat (3) @(negedge clk);
    chk(rdy_a && !done_a && !dq_a && rdy_b && !dq_b, "R1 in reset", {61'd0, rdy_a, done_a, dq_a}, 4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy_a && !done_a && !dq_a && rdy_b && !done_b && !dq_b, "R1 after release",
        {61'd0, rdy_a, done_a, dq_a}, 4);

    ba = mdl_a.n_log; bb = mdl_b.n_log;
    op(0, 32'h000, 0, 0, 0, "R3 cold read");
    chk_cnt(ba, bb, 2, 2, "R3");
    chk_log(0, ba, 0, 32'h000, 0, "R3 beat0"); chk_log(0, ba + 1, 0, 32'h008, 0, "R3 beat1");
    chk_log(1, bb, 0, 32'h000, 0, "R3 beat0 wt");

    ba = mdl_a.n_log; bb = mdl_b.n_log;
    op(0, 32'h008, 0, 1, 1, "R2 read hit");
    op(0, 32'h010, 0, 0, 0, "R3 read miss set1");
    op(0, 32'h018, 0, 1, 1, "R2 read hit set1");
    chk_cnt(ba, bb, 2, 2, "R2");

    ba = mdl_a.n_log; bb = mdl_b.n_log;
    op(1, 32'h008, W1, 1, 0, "R4/R5 write hit");
    chk_cnt(ba, bb, 0, 1, "R4 R5");
    chk_log(1, bb, 1, 32'h008, W1, "R5 write-through");
    op(0, 32'h008, 0, 1, 1, "R4 read back");

    ba = mdl_a.n_log; bb = mdl_b.n_log;
    op(1, 32'h100, W2, 0, 0, "R6 write miss");
    chk_cnt(ba, bb, 1, 1, "R6");
    chk_log(0, ba, 1, 32'h100, W2, "R6 forward");
    ba = mdl_a.n_log; bb = mdl_b.n_log;
    op(0, 32'h100, 0, 0, 0, "R6 no allocate");
    chk_cnt(ba, bb, 2, 2, "R6 refill");

    op(0, 32'h000, 0, 1, 1, "R9 touch way0");
    ba = mdl_a.n_log; bb = mdl_b.n_log;
    op(0, 32'h200, 0, 0, 0, "R8 clean victim");
    chk_cnt(ba, bb, 2, 2, "R8");
    op(0, 32'h000, 0, 1, 1, "R9 lru kept");
    op(0, 32'h300, 0, 0, 0, "R9 evict lru");

    ba = mdl_a.n_log; bb = mdl_b.n_log;
    op(0, 32'h200, 0, 0, 0, "R7 dirty victim");
    chk_cnt(ba, bb, 4, 2, "R7 R8");
    chk_log(0, ba,     1, 32'h000, {32'h0, 32'h5A5A_5A5A}, "R7 wb beat0");
    chk_log(0, ba + 1, 1, 32'h008, W1, "R7 wb beat1");
    chk_log(0, ba + 2, 0, 32'h200, 0, "R7 refill beat0");
    chk_log(0, ba + 3, 0, 32'h208, 0, "R7 refill beat1");
    chk_log(1, bb, 0, 32'h200, 0, "R8 wt refill");

    op(0, 32'h008, 0, 0, 0, "R7 data below");
    op(0, 32'h100, 0, 0, 0, "R6 data below");

    repeat (4) @(negedge clk);
    over = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  always @(posedge clk)
    if (cyc > 20000 && !over) begin
      over = 1'b1;
      n_err++; n_chk++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
endmodule